// File: doc/BRIEF.md
# Real-Time Counter with Alarm Channels

This block keeps a 32-bit up counter that advances once per real-time tick. The tick is a single-cycle enable from a slow timebase, and the counter moves only while a run bit is set. Three compare channels each hold a 32-bit match value. When the counter reaches a new value that equals a channel's match value and alarms are enabled, the channel sets its own sticky flag. In that case the block also emits a one-cycle interrupt/wake pulse. Channel 0 can optionally restart the counter from zero on the tick that follows its match. This gives a hardware-managed periodic alarm. With auto-restart off, software keeps a perpetual timebase and moves the match values ahead itself.

Software reaches the block through a flat register port with one write address and an independent combinational read address. The counter cannot be read or written directly. A set command copies the holding register into the counter, and a capture command copies the counter into the holding register. Both commands complete on the next tick while running, and a busy bit is visible for the duration of the transfer.

Register map, by address:
- Address 0 is the control/status register.
  - Write bits: bit 0 run, bit 1 alarm enable, bit 2 auto-restart, bit 3 set command, bit 4 capture command.
  - Read bits: bit 0 run, bit 1 alarm enable, bit 2 auto-restart, bit 3 busy, bits 4+i flag of channel i.
- Address 1 is the holding register.
- Addresses 2, 3 and 4 are the match values of channels 0, 1 and 2.
- All other addresses read as zero.

Top module: `rtcAlarmCounter`

## Requirements
- R1: After reset the control/status register reads 0, the holding register and every match value read 0, the counter is 0, and irqPulse is low.
- R2: On each cycle where tickEn is high and run (control bit 0) is 1, the counter moves by one, wrapping like any 32-bit unsigned value. When run is 0 or tickEn is low, the counter keeps its value.
- R3: A channel fires when the counter has just been given a new value, that value equals the channel's match value, and alarm enable (bit 1) is 1. Firing produces a one-cycle irqPulse in the following cycle and sets flag bit 4+i. The flag stays set through later ticks.
- R4: While alarm enable is 0, no channel fires. Any write of the control register with bit 1 at 0 clears all flags.
- R5: With auto-restart (bit 2) set, the first tick after a channel-0 firing loads the counter with 0 instead of incrementing it. Firings of channels 1 and 2 never restart the counter.
- R6: A channel does not fire again while the counter holds the same value. This holds even when alarms are disabled and re-enabled without changing the match value.
- R7: A control write with bits 0 and 3 set starts a set transfer. Busy (status bit 3) reads 1 until the first tick after the write. That tick loads the holding register into the counter and clears busy.
- R8: A control write with bits 0 and 4 set, and bit 3 clear, starts a capture transfer. The first tick after the write copies the counter value from before that tick into the holding register, and the counter still increments on that tick.
- R9: A command bit in a write whose run bit is 0 is ignored. A command written while busy is 1 is ignored, and the pending transfer completes unchanged.
- R10: A channel with match value 0 fires when the counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle real-time tick enable |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Write address |
| regWdata | input | 32 | Write data |
| regRdAddr | input | 3 | Read address |
| regRdata | output | 32 | Read data for regRdAddr (combinational) |
| irqPulse | output | 1 | One-cycle interrupt/wake pulse |

## Verification
The hardest situation to reach is a channel-0 match followed directly by a tick in the very next cycle. In that case the restart decision must come from the match being evaluated in that same cycle. A close second is a counter that sits on a matching value while alarms are toggled off and on.

The stimulus reaches specific counter values through the set command, so no long runs of ticks are needed. It then switches to a tick on every cycle, with a small channel-0 match value and auto-restart on. A value near 0xFFFFFFFF is preloaded to cover the wrap. A behavioural model in the bench follows every cycle and compares the pulse and the selected register.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int ADDR_CTRL       = 0;
  localparam int ADDR_HOLD       = 1;
  localparam int ADDR_MATCH_BASE = 2;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_AEN = 1;
  localparam int CTRL_AR  = 2;
  localparam int CTRL_SET = 3;
  localparam int CTRL_CAP = 4;
  localparam int CTRL_WR_W = 5;

  localparam int STAT_BUSY     = 3;
  localparam int STAT_FLAG_LSB = 4;

  typedef struct packed {
    logic incr;
    logic load;
    logic clear;
    logic capture;
  } cntStrobe_t;

  typedef enum logic [1:0] {
    XFER_IDLE    = 2'd0,
    XFER_SET     = 2'd1,
    XFER_CAPTURE = 2'd2
  } xferOp_t;
endpackage

// File: rtl/rtcDatapath.sv
module rtcDatapath import rtcAlarmPkg::*; #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cntStrobe_t               stb,
  input  logic                     regWr,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [CNT_W-1:0]         regWdata,
  output logic [CNT_W-1:0]         count,
  output logic [CNT_W-1:0]         holdVal,
  output logic [NUM_CH*CNT_W-1:0]  matchFlat,
  output logic [NUM_CH-1:0]        rawHit
);
  logic fresh;
  logic holdWr;

  assign holdWr = regWr && (regAddr == ADDR_W'(ADDR_HOLD));

  // counter, new-value marker and holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      fresh   <= 1'b0;
      holdVal <= '0;
    end else begin
      fresh <= stb.incr | stb.load | stb.clear;
      if (stb.load)       count <= holdVal;
      else if (stb.clear) count <= '0;
      else if (stb.incr)  count <= count + CNT_W'(1);
      if (stb.capture)    holdVal <= count;
      else if (holdWr)    holdVal <= regWdata;
    end
  end

  // compare channels
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] matchQ;
    logic             matchWr;
    assign matchWr = regWr && (regAddr == ADDR_W'(ADDR_MATCH_BASE + g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        matchQ <= '0;
      else if (matchWr) matchQ <= regWdata;
    end
    assign matchFlat[g*CNT_W +: CNT_W] = matchQ;
    assign rawHit[g] = fresh && (count == matchQ);
  end
endmodule

// File: rtl/rtcControl.sv
module rtcControl import rtcAlarmPkg::*; #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CTRL_WR_W-1:0] ctrlWdata,
  input  logic [NUM_CH-1:0]    rawHit,
  output cntStrobe_t           stb,
  output logic [DATA_W-1:0]    ctrlStatus,
  output logic                 irqPulse,
  output logic                 run,
  output logic                 alarmEn,
  output logic                 autoReset,
  output logic                 busy
);
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] alarmEvt;
  xferOp_t           xferOp;
  logic              armClear;
  logic              tick;
  logic              ctrlWr;
  logic              clearNow;

  assign ctrlWr   = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
  assign tick     = tickEn && run;
  assign alarmEvt = rawHit & {NUM_CH{alarmEn}};
  assign clearNow = autoReset && (armClear || alarmEvt[0]);
  assign busy     = (xferOp != XFER_IDLE);

  // one counter action per tick: load > restart > increment
  always_comb begin
    stb = '0;
    if (tick) begin
      stb.capture = (xferOp == XFER_CAPTURE);
      if (xferOp == XFER_SET) stb.load  = 1'b1;
      else if (clearNow)      stb.clear = 1'b1;
      else                    stb.incr  = 1'b1;
    end
  end

  always_comb begin
    ctrlStatus = '0;
    ctrlStatus[CTRL_RUN]  = run;
    ctrlStatus[CTRL_AEN]  = alarmEn;
    ctrlStatus[CTRL_AR]   = autoReset;
    ctrlStatus[STAT_BUSY] = busy;
    ctrlStatus[STAT_FLAG_LSB +: NUM_CH] = flags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run       <= 1'b0;
      alarmEn   <= 1'b0;
      autoReset <= 1'b0;
      flags     <= '0;
      irqPulse  <= 1'b0;
      armClear  <= 1'b0;
      xferOp    <= XFER_IDLE;
    end else begin
      irqPulse <= |alarmEvt;
      if (ctrlWr && !ctrlWdata[CTRL_AEN]) flags <= '0;
      else                                flags <= flags | alarmEvt;
      if (tick)                               armClear <= 1'b0;
      else if (alarmEvt[0] && autoReset)      armClear <= 1'b1;
      if (tick && busy) xferOp <= XFER_IDLE;
      else if (ctrlWr && ctrlWdata[CTRL_RUN] && !busy) begin
        if (ctrlWdata[CTRL_SET])      xferOp <= XFER_SET;
        else if (ctrlWdata[CTRL_CAP]) xferOp <= XFER_CAPTURE;
      end
      if (ctrlWr) begin
        run       <= ctrlWdata[CTRL_RUN];
        alarmEn   <= ctrlWdata[CTRL_AEN];
        autoReset <= ctrlWdata[CTRL_AR];
      end
    end
  end
endmodule

// File: rtl/rtcAlarmCounter.sv
module rtcAlarmCounter import rtcAlarmPkg::*; #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [CNT_W-1:0]  regRdata,
  output logic              irqPulse
);
  cntStrobe_t               stb;
  logic [CNT_W-1:0]         count;
  logic [CNT_W-1:0]         holdVal;
  logic [NUM_CH*CNT_W-1:0]  matchFlat;
  logic [NUM_CH-1:0]        rawHit;
  logic [CNT_W-1:0]         ctrlStatus;
  logic                     run;
  logic                     alarmEn;
  logic                     autoReset;
  logic                     busy;

  rtcControl #(.NUM_CH(NUM_CH), .DATA_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regAddr(regAddr),
    .ctrlWdata(regWdata[CTRL_WR_W-1:0]), .rawHit(rawHit), .stb(stb),
    .ctrlStatus(ctrlStatus), .irqPulse(irqPulse), .run(run), .alarmEn(alarmEn),
    .autoReset(autoReset), .busy(busy)
  );

  rtcDatapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .count(count), .holdVal(holdVal),
    .matchFlat(matchFlat), .rawHit(rawHit)
  );

  always_comb begin
    regRdata = '0;
    if (regRdAddr == ADDR_W'(ADDR_CTRL)) regRdata = ctrlStatus;
    if (regRdAddr == ADDR_W'(ADDR_HOLD)) regRdata = holdVal;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regRdAddr == ADDR_W'(ADDR_MATCH_BASE + i)) regRdata = matchFlat[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/rtcAlarmChecker.sv
module rtcAlarmChecker #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              irqPulse,
  input logic [CNT_W-1:0]  count,
  input logic [NUM_CH-1:0] rawHit,
  input logic              alarmEn,
  input logic              autoReset,
  input logic              busy,
  input logic              incrStb,
  input logic              loadStb,
  input logic              clearStb
);
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count));

  p_one_action_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({incrStb, loadStb, clearStb}));

  p_hit_raises_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((|rawHit) && alarmEn) |=> irqPulse);

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(alarmEn));

  p_restart_needs_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |-> autoReset);

  p_restart_zeroes_r5: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (count == '0));

  p_frozen_no_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (rawHit == '0));

  p_busy_ends_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tickEn));
endmodule

bind rtcAlarmCounter rtcAlarmChecker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .irqPulse(irqPulse), .count(count),
  .rawHit(rawHit), .alarmEn(alarmEn), .autoReset(autoReset), .busy(busy),
  .incrStb(stb.incr), .loadStb(stb.load), .clearStb(stb.clear)
);

// File: tb/rtcAlarmCounter_tb_top.sv
`timescale 1ns/1ps
module rtcAlarmCounter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdata;
  logic        irqPulse;

  int checks = 0;
  int failures = 0;
  int irqCount = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtcAlarmCounter dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdAddr(regRdAddr), .regRdata(regRdata), .irqPulse(irqPulse)
  );

  // behavioural reference model
  logic [31:0] mCnt, mHold, oldCnt;
  logic [31:0] mMatch [3];
  bit mRun, mAen, mAr, mArm, mFresh, mIrq, tk, nFresh;
  bit [2:0] mFlags, ev;
  int mPend; // 0 none, 1 set, 2 capture

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mHold = 0; mRun = 0; mAen = 0; mAr = 0; mArm = 0;
      mFresh = 0; mIrq = 0; mFlags = 0; mPend = 0;
      for (int i = 0; i < 3; i++) mMatch[i] = 0;
    end else begin
      for (int i = 0; i < 3; i++) ev[i] = mFresh && mAen && (mCnt == mMatch[i]);
      tk = tickEn && mRun;
      oldCnt = mCnt;
      nFresh = 0;
      if (tk) begin
        nFresh = 1;
        if (mPend == 1) mCnt = mHold;
        else if (mAr && (mArm || ev[0])) mCnt = 0;
        else mCnt = mCnt + 1;
      end
      if (tk && mPend == 2) mHold = oldCnt;
      else if (regWr && regAddr == 1) mHold = regWdata;
      for (int i = 0; i < 3; i++) if (regWr && regAddr == 3'(2 + i)) mMatch[i] = regWdata;
      if (tk) mArm = 0; else if (ev[0] && mAr) mArm = 1;
      mIrq = |ev;
      if (regWr && regAddr == 0 && !regWdata[1]) mFlags = 0; else mFlags = mFlags | ev;
      if (tk && mPend != 0) mPend = 0;
      else if (regWr && regAddr == 0 && regWdata[0] && mPend == 0)
        mPend = regWdata[3] ? 1 : (regWdata[4] ? 2 : 0);
      if (regWr && regAddr == 0) begin mRun = regWdata[0]; mAen = regWdata[1]; mAr = regWdata[2]; end
      mFresh = nFresh;
    end
  end

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: mRead = {25'd0, mFlags, (mPend != 0), mAr, mAen, mRun};
      3'd1: mRead = mHold;
      3'd2: mRead = mMatch[0];
      3'd3: mRead = mMatch[1];
      3'd4: mRead = mMatch[2];
      default: mRead = 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk(irqPulse == mIrq, "R3 irqPulse vs model", 32'(irqPulse), 32'(mIrq));
      chk(regRdata == mRead(regRdAddr), (regRdAddr == 0) ? "R4 status vs model" : "R8 register vs model",
          regRdata, mRead(regRdAddr));
    end
  end

  always @(negedge clk) if (rstN && irqPulse) irqCount++;

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdAddr = a;
    #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  int irqBase;

  initial begin
    idle(4);
    rstN = 1'b1;
    // R1 reset state
    rdChk(3'd0, 32'h0, "R1 status after reset");
    rdChk(3'd1, 32'h0, "R1 hold after reset");
    rdChk(3'd3, 32'h0, "R1 match1 after reset");
    chk(irqPulse == 1'b0, "R1 irq after reset", 32'(irqPulse), 0);
    wrReg(3'd0, 32'h11); ticks(1);
    rdChk(3'd1, 32'h0, "R1 counter zero at reset");           // cnt now 1

    // R7 set transfer with busy
    wrReg(3'd1, 32'd10);
    wrReg(3'd0, 32'h09);
    rdChk(3'd0, 32'h09, "R7 busy while set pending");
    ticks(1);                                                  // cnt 10
    rdChk(3'd0, 32'h01, "R7 busy cleared by first tick");
    // R8 capture
    wrReg(3'd0, 32'h11); ticks(1);                             // hold 10, cnt 11
    rdChk(3'd1, 32'd10, "R8 capture value before tick");
    // R2 freeze then count
    wrReg(3'd0, 32'h00); ticks(3);
    wrReg(3'd0, 32'h11); ticks(1);                             // hold 11, cnt 12
    rdChk(3'd1, 32'd11, "R2 counter frozen when run low");
    ticks(3);                                                  // cnt 15
    wrReg(3'd0, 32'h11); ticks(1);                             // hold 15, cnt 16
    rdChk(3'd1, 32'd15, "R2 one step per tick");
    // R9 ignored commands
    wrReg(3'd0, 32'h08);
    rdChk(3'd0, 32'h00, "R9 command ignored with run low");
    ticks(1);
    wrReg(3'd0, 32'h11);
    wrReg(3'd0, 32'h09);                                       // ignored, busy
    ticks(1);                                                  // hold 16, cnt 17
    wrReg(3'd0, 32'h11); ticks(1);                             // hold 17, cnt 18
    rdChk(3'd1, 32'd17, "R9 command while busy ignored");

    // R3 match on channel 1
    irqBase = irqCount;
    wrReg(3'd3, 32'd20);
    wrReg(3'd0, 32'h03);
    ticks(2); idle(3);                                         // cnt 20
    chk(irqCount - irqBase == 1, "R3 one pulse on match", 32'(irqCount - irqBase), 1);
    rdChk(3'd0, 32'h23, "R3 channel 1 flag set");
    ticks(1);
    rdChk(3'd0, 32'h23, "R3 flag sticky");
    // R4 disable clears flags and suppresses
    wrReg(3'd0, 32'h01);
    rdChk(3'd0, 32'h01, "R4 disable clears flags");
    irqBase = irqCount;
    wrReg(3'd4, 32'd22);
    ticks(1); idle(3);                                         // cnt 22
    chk(irqCount == irqBase, "R4 no pulse while disabled", 32'(irqCount - irqBase), 0);
    rdChk(3'd0, 32'h01, "R4 no flag while disabled");
    // R6 re-enable without counter change
    wrReg(3'd0, 32'h03); idle(4);
    chk(irqCount == irqBase, "R6 no re-fire on same value", 32'(irqCount - irqBase), 0);
    rdChk(3'd0, 32'h03, "R6 flags still clear");

    // R5 auto-restart only from channel 0
    wrReg(3'd2, 32'd25);
    wrReg(3'd3, 32'd24);
    wrReg(3'd0, 32'h07);
    ticks(4);                                                  // 23,24,25,0
    wrReg(3'd0, 32'h17); ticks(1);                             // hold 0, cnt 1
    rdChk(3'd1, 32'd0, "R5 counter restarted after channel 0");
    chk(irqCount - irqBase == 2, "R5 pulses for ch1 and ch0", 32'(irqCount - irqBase), 2);
    rdChk(3'd0, 32'h37, "R5 both flags set");

    // R10 wrap to zero
    wrReg(3'd0, 32'h01);
    wrReg(3'd1, 32'hFFFF_FFFE);
    wrReg(3'd2, 32'd0);
    irqBase = irqCount;
    wrReg(3'd0, 32'h0B); ticks(1);                             // cnt FFFFFFFE
    ticks(2); idle(3);                                         // cnt 0
    chk(irqCount - irqBase == 1, "R10 pulse at wrap", 32'(irqCount - irqBase), 1);
    rdChk(3'd0, 32'h13, "R10 channel 0 flag at wrap");
    wrReg(3'd0, 32'h13); ticks(1);
    rdChk(3'd1, 32'd0, "R10 counter wrapped to zero");

    // R5 back-to-back ticks with auto-restart
    wrReg(3'd0, 32'h01);
    wrReg(3'd2, 32'd7);
    wrReg(3'd1, 32'd0);
    wrReg(3'd0, 32'h0F);
    irqBase = irqCount;
    @(negedge clk); tickEn = 1'b1;
    idle(300);
    tickEn = 1'b0;
    idle(3);
    chk(irqCount - irqBase >= 30, "R5 periodic restart with tick every cycle",
        32'(irqCount - irqBase), 30);
    idle(2);
    summary();
  end
endmodule